// File: doc/BRIEF.md
# Full-Duplex SPI Transaction Engine

This block is a serial peripheral master that carries out one full-duplex exchange of one to four bytes per command. A command brings four transmit bytes, a one-hot slave-select mask and a byte count. The command is checked before any bus activity starts. A mask with two or more bits set, or a count above four, ends at once with an error result. An accepted command asserts the chosen select, shifts the bytes out most-significant bit first, and captures the input line on every bit. Each received byte is written over the buffer slot of the byte that was just sent.

The serial clock idles low. Its half period is set per command by a divider value. The select line frames the transfer with one half period of lead before the first rising edge and one half period of trail after the last falling edge. A busy flag covers the whole transaction. Commands offered while it is high are dropped. The four-byte buffer can be read at any time and holds the last result.

Top module: `duplex_spi_top`

## Requirements
- R1: Transmit byte k (k = 0..3) is taken from cmdTx[8k+7:8k] and is sent after byte k-1. cmdSel is an active-high select mask and cmdLen is the byte count.
- R2: If cmdSel has more than one bit set, done pulses one cycle after acceptance with ok=0. busy stays low, no select or clock activity occurs, and rdData is unchanged.
- R3: If cmdLen is greater than 4, the command is rejected in the same way as in R2.
- R4: cmdLen=0 completes with ok=1 and no sclk pulses. The select is asserted for one half period and then released.
- R5: Bits leave on mosi MSB first. mosi changes only while sclk is low and holds steady while sclk is high.
- R6: miso is sampled at the end of each high phase, just before sclk falls. The first bit received becomes the MSB of the received byte.
- R7: After a successful command, rdData byte k holds the received byte for k < cmdLen and the transmit byte for k >= cmdLen.
- R8: selOut equals cmdSel from one half period before the first rising edge until one half period after the last falling edge. At completion it returns to all zero.
- R9: sclk idles low. Each half period lasts halfDiv+1 clock cycles. An accepted command holds busy for (halfDiv+1)*(1+16*cmdLen) cycles and gives exactly 8*cmdLen rising edges.
- R10: busy rises in the cycle after acceptance and falls in the cycle in which done (ok=1) pulses. A cmdValid seen while busy is ignored.
- R11: After reset, busy, done, ok, sclk and selOut are low and rdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low synchronous reset |
| cmdValid | input | 1 | command strobe, taken when idle |
| cmdTx | input | 32 | four transmit bytes, byte k at [8k+7:8k] |
| cmdSel | input | 8 | slave-select mask, at most one bit set |
| cmdLen | input | 8 | byte count, 0 to 4 valid |
| halfDiv | input | 8 | half period of sclk minus one, in clock cycles |
| busy | output | 1 | transaction in progress |
| done | output | 1 | one-cycle completion pulse |
| ok | output | 1 | result status, valid while done is high |
| rdData | output | 32 | buffer read-back, byte k at [8k+7:8k] |
| sclk | output | 1 | serial clock, idle low |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| selOut | output | 8 | active-high slave selects |

## Verification
A rejected command gives its done pulse one cycle after the accepting edge. An accepted one gives it (halfDiv+1)*(1+16*cmdLen) cycles later, and rdData is valid from that pulse on. The bench drives inputs and samples outputs on the falling clock edge. For each command it walks cycle by cycle until done appears. On the way it counts busy cycles, rising sclk edges, the lead and trail half periods of the select, and the bits captured by a slave model. Each count is compared with the value computed from that command's length and divider.

// File: rtl/duplex_spi_pkg.sv
package duplex_spi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_TRAIL} spiState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCmd;   // capture command bytes
    logic sample;    // shift miso into the working byte
    logic commit;    // last bit of a byte: store into its slot
  } dpStrobe_t;
endpackage

// File: rtl/duplex_spi_dp.sv
module duplex_spi_dp
  import duplex_spi_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  localparam int BUF_W = MAX_BYTES * 8,
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [BUF_W-1:0] cmdTx,
  input  logic             miso,
  output logic             mosi,
  output logic [BUF_W-1:0] rdData
);
  logic [7:0] bufMem [MAX_BYTES];
  logic [7:0] shReg;
  logic [IDX_W-1:0] idx, nextIdx;
  logic [7:0] rxByte;

  assign nextIdx = (idx == IDX_W'(MAX_BYTES - 1)) ? '0 : idx + IDX_W'(1);
  assign rxByte  = {shReg[6:0], miso};
  assign mosi    = shReg[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < MAX_BYTES; k++) bufMem[k] <= '0;
      shReg <= '0;
      idx   <= '0;
    end else if (strobe.loadCmd) begin
      for (int k = 0; k < MAX_BYTES; k++) bufMem[k] <= cmdTx[8*k +: 8];
      shReg <= cmdTx[7:0];
      idx   <= '0;
    end else if (strobe.sample) begin
      if (strobe.commit) begin
        bufMem[idx] <= rxByte;
        shReg       <= bufMem[nextIdx];
        idx         <= nextIdx;
      end else begin
        shReg <= rxByte;
      end
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_rd
    assign rdData[8*g +: 8] = bufMem[g];
  end
endmodule

// File: rtl/duplex_spi_ctrl.sv
module duplex_spi_ctrl
  import duplex_spi_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int NUM_SEL   = 8,
  parameter int LEN_W     = 8,
  parameter int DIV_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [NUM_SEL-1:0] cmdSel,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic [DIV_W-1:0]   halfDiv,
  output dpStrobe_t          strobe,
  output logic               busy,
  output logic               done,
  output logic               ok,
  output logic               sclk,
  output logic [NUM_SEL-1:0] selOut
);
  spiState_e state;
  logic [DIV_W-1:0] cnt, divReg;
  logic [2:0] bitCnt;
  logic [LEN_W-1:0] bytesLeft;
  logic selGood, lenGood, cmdGood, phaseEnd, lastBit, lastByte;

  assign selGood  = (cmdSel & (cmdSel - NUM_SEL'(1))) == '0;
  assign lenGood  = cmdLen <= LEN_W'(MAX_BYTES);
  assign cmdGood  = selGood && lenGood;
  assign phaseEnd = cnt == '0;
  assign lastBit  = bitCnt == 3'd7;
  assign lastByte = bytesLeft == LEN_W'(1);

  assign strobe.loadCmd = (state == ST_IDLE) && cmdValid && cmdGood;
  assign strobe.sample  = (state == ST_HIGH) && phaseEnd;
  assign strobe.commit  = strobe.sample && lastBit;

  assign busy = state != ST_IDLE;
  assign sclk = state == ST_HIGH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      divReg    <= '0;
      bitCnt    <= '0;
      bytesLeft <= '0;
      selOut    <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            if (cmdGood) begin
              selOut    <= cmdSel;
              divReg    <= halfDiv;
              cnt       <= halfDiv;
              bitCnt    <= '0;
              bytesLeft <= cmdLen;
              state     <= (cmdLen == '0) ? ST_TRAIL : ST_LOW;
            end else begin
              done <= 1'b1;
              ok   <= 1'b0;
            end
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state <= ST_HIGH;
            cnt   <= divReg;
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            cnt    <= divReg;
            bitCnt <= bitCnt + 3'd1;
            if (lastBit) begin
              bytesLeft <= bytesLeft - LEN_W'(1);
              state     <= lastByte ? ST_TRAIL : ST_LOW;
            end else begin
              state <= ST_LOW;
            end
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        ST_TRAIL: begin
          if (phaseEnd) begin
            state  <= ST_IDLE;
            selOut <= '0;
            done   <= 1'b1;
            ok     <= 1'b1;
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/duplex_spi_top.sv
module duplex_spi_top
  import duplex_spi_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int NUM_SEL   = 8,
  parameter int LEN_W     = 8,
  parameter int DIV_W     = 8,
  localparam int BUF_W = MAX_BYTES * 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [BUF_W-1:0]   cmdTx,
  input  logic [NUM_SEL-1:0] cmdSel,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic [DIV_W-1:0]   halfDiv,
  output logic               busy,
  output logic               done,
  output logic               ok,
  output logic [BUF_W-1:0]   rdData,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] selOut
);
  dpStrobe_t strobe;

  duplex_spi_ctrl #(
    .MAX_BYTES(MAX_BYTES), .NUM_SEL(NUM_SEL), .LEN_W(LEN_W), .DIV_W(DIV_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSel(cmdSel),
    .cmdLen(cmdLen), .halfDiv(halfDiv), .strobe(strobe), .busy(busy),
    .done(done), .ok(ok), .sclk(sclk), .selOut(selOut)
  );

  duplex_spi_dp #(.MAX_BYTES(MAX_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdTx(cmdTx),
    .miso(miso), .mosi(mosi), .rdData(rdData)
  );
endmodule

// File: rtl/duplex_spi_chk.sv
module duplex_spi_chk #(
  parameter int NUM_SEL = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               done,
  input logic               ok,
  input logic               sclk,
  input logic               mosi,
  input logic [NUM_SEL-1:0] selOut
);
  // R8: never more than one select active
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOut));

  // R9: clock and selects quiet when idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclk && selOut == '0));

  // R5: mosi holds across a high phase
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R8: select cannot move while the clock is high
  p_sel_steady_r8: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(selOut));

  // R10: a successful completion ends the busy period
  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && ok) |-> $fell(busy));

  // R2 / R3: a rejection never starts the bus
  p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !ok) |-> (!busy && !$past(busy) && selOut == '0));
endmodule

bind duplex_spi_top duplex_spi_chk #(.NUM_SEL(NUM_SEL)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .ok(ok),
  .sclk(sclk), .mosi(mosi), .selOut(selOut)
);

// File: tb/test_duplex_spi_top.sv
module test_duplex_spi_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [31:0] cmdTx = '0;
  logic [7:0] cmdSel = '0, cmdLen = '0, halfDiv = '0;
  logic busy, done, ok, sclk, mosi, miso;
  logic [31:0] rdData;
  logic [7:0] selOut;

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] slShift = '0, slRx = '0;

  always #10 clk = ~clk;  // 50 MHz

  duplex_spi_top i_duplex_spi_top (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdTx(cmdTx),
    .cmdSel(cmdSel), .cmdLen(cmdLen), .halfDiv(halfDiv), .busy(busy),
    .done(done), .ok(ok), .rdData(rdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .selOut(selOut)
  );

  // slave model: captures mosi on rising sclk, advances miso on falling sclk
  assign miso = slShift[31];
  always @(posedge sclk) slRx <= {slRx[30:0], mosi};
  always @(negedge sclk) slShift <= {slShift[30:0], 1'b0};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit cond, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // results of the last command
  int busyCnt, edgeCnt, leadCnt, trailCnt;
  logic [7:0] selSeen;
  logic gotOk;

  task automatic runCmd(input logic [31:0] tx, input logic [7:0] sel,
                        input logic [7:0] len, input logic [7:0] div,
                        input logic [31:0] resp);
    logic prevSclk;
    slShift = {resp[7:0], resp[15:8], resp[23:16], resp[31:24]};
    slRx = '0;
    busyCnt = 0; edgeCnt = 0; leadCnt = 0; trailCnt = 0; selSeen = '0;
    prevSclk = 1'b0;
    @(negedge clk);
    cmdTx = tx; cmdSel = sel; cmdLen = len; halfDiv = div; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int g = 0; g < 20000; g++) begin
      if (done) break;
      if (busy) busyCnt++;
      if (sclk && !prevSclk) edgeCnt++;
      if (selOut != '0 && edgeCnt == 0 && !sclk) leadCnt++;
      if (sclk) trailCnt = 0;
      else if (selOut != '0) trailCnt++;
      selSeen |= selOut;
      prevSclk = sclk;
      @(negedge clk);
    end
    gotOk = ok;
  endtask

  localparam int NV = 6;
  // {tx, sel, len, div, resp}; byte k of tx/resp at [8k+7:8k]
  localparam logic [87:0] VEC [NV] = '{
    {32'h44332211, 8'h01, 8'd1, 8'd0, 32'h0000005A},
    {32'h8001FF7E, 8'h04, 8'd2, 8'd1, 32'h0000C3A6},
    {32'hDEADBEEF, 8'h80, 8'd3, 8'd2, 32'h00123456},
    {32'h0F1E2D3C, 8'h10, 8'd4, 8'd0, 32'h96E17852},
    {32'h12345678, 8'h00, 8'd2, 8'd0, 32'h0000FFFF},
    {32'hCAFEF00D, 8'h02, 8'd0, 8'd3, 32'hAAAAAAAA}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !ok && !sclk, "R11 idle flags", {28'd0, busy, done, ok, sclk}, 0);
    check(selOut == 0, "R11 selects", selOut, 0);
    check(rdData == 0, "R11 buffer", rdData, 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [31:0] tx, resp, expRd, expRx;
      logic [7:0] sel, len, div;
      int h, l;
      {tx, sel, len, div, resp} = VEC[v];
      h = int'(div) + 1; l = int'(len);
      expRd = tx; expRx = '0;
      for (int k = 0; k < l; k++) begin
        expRd[8*k +: 8] = resp[8*k +: 8];
        expRx = (expRx << 8) | 32'(tx[8*k +: 8]);
      end
      runCmd(tx, sel, len, div, resp);
      check(gotOk, "R10 ok status", {31'd0, gotOk}, 1);
      check(rdData == expRd, "R7 R6 read-back in place", rdData, expRd);
      check(slRx == expRx, "R1 R5 bytes sent MSB first", slRx, expRx);
      check(edgeCnt == 8 * l, "R9 R4 rising edge count", edgeCnt, 8 * l);
      check(busyCnt == h * (1 + 16 * l), "R9 busy length", busyCnt, h * (1 + 16 * l));
      check(selSeen == sel, "R8 select used", selSeen, sel);
      check(leadCnt == ((sel != 0) ? h : 0), "R8 lead half period", leadCnt, (sel != 0) ? h : 0);
      check(trailCnt == ((sel != 0) ? h : 0), "R8 trail half period", trailCnt, (sel != 0) ? h : 0);
      check(selOut == 0 && !busy, "R8 released at end", selOut, 0);
    end

    // R2: two selects set -> error, buffer untouched (last vector left CAFEF00D)
    runCmd(32'h01020304, 8'h03, 8'd2, 8'd0, 32'hFFFFFFFF);
    check(!gotOk && busyCnt == 0, "R2 multi-select rejected", {31'd0, gotOk}, 0);
    check(edgeCnt == 0 && selSeen == 0, "R2 no bus activity", edgeCnt, 0);
    check(rdData == 32'hCAFEF00D, "R2 buffer unchanged", rdData, 32'hCAFEF00D);

    // R3: length above four -> error
    runCmd(32'h01020304, 8'h01, 8'd5, 8'd0, 32'hFFFFFFFF);
    check(!gotOk && busyCnt == 0, "R3 long length rejected", {31'd0, gotOk}, 0);
    check(edgeCnt == 0 && selSeen == 0, "R3 no bus activity", edgeCnt, 0);
    check(rdData == 32'hCAFEF00D, "R3 buffer unchanged", rdData, 32'hCAFEF00D);

    // R10: a command offered while busy is ignored
    slShift = {8'h3C, 24'h0}; slRx = '0;
    @(negedge clk);
    cmdTx = 32'h11223344; cmdSel = 8'h08; cmdLen = 8'd1; halfDiv = 8'd1; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy, "R10 busy after accept", {31'd0, busy}, 1);
    repeat (5) @(negedge clk);
    cmdTx = 32'hFFFFFFFF; cmdSel = 8'h01; cmdLen = 8'd4; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int g = 0; g < 1000; g++) begin
      if (done) break;
      @(negedge clk);
    end
    check(rdData == 32'h1122333C, "R10 busy command ignored", rdData, 32'h1122333C);
    repeat (4) @(negedge clk);
    check(!busy && selOut == 0, "R10 no second transfer", {31'd0, busy}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule